// File: doc/BRIEF.md
# Field-Based Framebuffer Address Generator

This block produces the byte address at which each captured 32-bit video word is written into memory. Software programs two base addresses, one for each video field. When a field begins, the block picks one of them and copies it into an internal working pointer. Each word that the memory side accepts then moves that pointer forward by one word. The software-visible base registers never change during capture, so software can set up the next buffer while the current field is still being stored.

Two capture modes are supported. In interlaced mode each field goes to its own buffer: the first field starts at the first base and the second field at the second base. In progressive mode a single buffer is used, and it always starts at the second base. Bases are aligned to 16 bytes, which is eight 16-bit pixels.

The word transfer itself is a valid/ready exchange owned by the memory side. The block only sees `xfer_accept`, which is high in each cycle where valid and ready are both high. The block never applies back-pressure. While no word is accepted, the address simply holds. Control pins are plain levels or strobes.

Top module: `fb_addr_gen`

## Requirements
- R1: While `rst_n` is low, both base registers and `wr_addr` are zero.
- R2: A base register write stores `base_wdata` with its lowest 4 bits forced to 0, so the value seen later on `wr_addr` at field start has bits [3:0] = 0.
- R3: When `interlaced`=1 and `field_start` is high, `wr_addr` on the next cycle equals the first base (register select 0) if `field_id`=0, and the second base (register select 1) if `field_id`=1.
- R4: When `interlaced`=0 and `field_start` is high, `wr_addr` on the next cycle equals the second base, whatever the value of `field_id`.
- R5: A cycle with `xfer_accept`=1 and `field_start`=0 makes `wr_addr` on the next cycle equal to the previous value plus 4.
- R6: Writing a base register never changes `wr_addr` mid-field. The new value is used only at a later `field_start`. A write in the same cycle as `field_start` is not used by that reload.
- R7: If `field_start` and `xfer_accept` are both high in one cycle, the reload wins and `wr_addr` shows the newly selected base, not that base plus 4.
- R8: In a cycle with neither `field_start` nor `xfer_accept`, `wr_addr` keeps its value.
- R9: The address wraps modulo 2^ADDR_W: a pointer at the top word rolls over to 0 on the next accepted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Base register write strobe |
| base_sel | input | 1 | 0 selects the first-field base, 1 selects the second-field base |
| base_wdata | input | ADDR_W | Base address write data; bits [3:0] are ignored |
| interlaced | input | 1 | 1 = interlaced capture, 0 = progressive capture |
| field_start | input | 1 | One-cycle pulse at the start of a field |
| field_id | input | 1 | Field being started: 0 = first, 1 = second |
| xfer_accept | input | 1 | High when a 32-bit word is accepted by memory (valid and ready) |
| wr_addr | output | ADDR_W | Current byte write address |

## Verification
The hardest cases to reach are the coincidences: a field start in the same cycle as a transfer accept, and a base write in the same cycle as the reload that would use it. Both are shown only by the exact address one cycle later. Directed steps drive these pins together on purpose. A behavioural model then says which value has to win. A base programmed 16 bytes below the top of the address space is followed by accepted words, which forces the pointer through wrap-around. A long random stretch then mixes modes, fields, writes and accepts against the model on every clock.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
  typedef enum logic { FIELD_FIRST = 1'b0, FIELD_SECOND = 1'b1 } field_e;
  typedef enum logic { MODE_PROG = 1'b0, MODE_INTL = 1'b1 } cap_mode_e;
  localparam int unsigned NUM_BASES = 2;
  localparam int unsigned BASE_SEL_W = $clog2(NUM_BASES);
endpackage

// File: rtl/fbag_base_regs.sv
module fbag_base_regs
  import fbag_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [BASE_SEL_W-1:0]              sel,
  input  logic [ADDR_W-1:0]                  wdata,
  output logic [NUM_BASES-1:0][ADDR_W-1:0]   base_q
);
  logic [ALIGN_BITS-1:0] unused_low;
  assign unused_low = wdata[ALIGN_BITS-1:0];

  for (genvar i = 0; i < NUM_BASES; i++) begin : g_base
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0;
      end else if (we && (sel == BASE_SEL_W'(i))) begin
        base_q[i] <= {wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/fbag_base_sel.sv
module fbag_base_sel
  import fbag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [NUM_BASES-1:0][ADDR_W-1:0] base_q,
  input  logic                             interlaced,
  input  logic                             field_id,
  output logic [ADDR_W-1:0]                base_pick
);
  cap_mode_e mode;
  field_e    fld;
  logic [BASE_SEL_W-1:0] idx;

  always_comb begin
    mode = cap_mode_e'(interlaced);
    fld  = field_e'(field_id);
    if (mode == MODE_INTL && fld == FIELD_FIRST) idx = BASE_SEL_W'(0);
    else                                          idx = BASE_SEL_W'(1);
    base_pick = base_q[idx];
  end
endmodule

// File: rtl/fbag_wptr.sv
module fbag_wptr #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              advance,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= load_val;
    else if (advance) ptr <= ptr + STEP;
  end
endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
  import fbag_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 4,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic              base_sel,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              interlaced,
  input  logic              field_start,
  input  logic              field_id,
  input  logic              xfer_accept,
  output logic [ADDR_W-1:0] wr_addr
);
  logic [NUM_BASES-1:0][ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0]                base_pick;

  fbag_base_regs #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(base_we), .sel(base_sel),
    .wdata(base_wdata), .base_q(base_q)
  );

  fbag_base_sel #(.ADDR_W(ADDR_W)) u_sel (
    .base_q(base_q), .interlaced(interlaced), .field_id(field_id),
    .base_pick(base_pick)
  );

  fbag_wptr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(field_start), .load_val(base_pick),
    .advance(xfer_accept), .ptr(wr_addr)
  );
endmodule

// File: rtl/fbag_chk.sv
module fbag_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 4,
  parameter int unsigned WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              field_start,
  input logic              xfer_accept,
  input logic [ADDR_W-1:0] wr_addr
);
  localparam int unsigned WB = $clog2(WORD_BYTES);

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_accept && !field_start) |=> wr_addr == $past(wr_addr) + ADDR_W'(WORD_BYTES));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_accept && !field_start) |=> $stable(wr_addr));

  p_load_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> wr_addr[ALIGN_BITS-1:0] == '0);

  p_reload_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && xfer_accept) |=> wr_addr[ALIGN_BITS-1:0] == '0);

  p_word_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr[WB-1:0] == '0);
endmodule

bind fb_addr_gen fbag_chk #(
  .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .field_start(field_start),
  .xfer_accept(xfer_accept), .wr_addr(wr_addr)
);

// File: tb/sim_fb_addr_gen.sv
`timescale 1ns/1ps
module sim_fb_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic        base_sel = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        interlaced = 1'b0;
  logic        field_start = 1'b0;
  logic        field_id = 1'b0;
  logic        xfer_accept = 1'b0;
  logic [31:0] wr_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_base1, m_base2, m_ptr;

  always #2 clk = ~clk;

  fb_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_sel(base_sel),
    .base_wdata(base_wdata), .interlaced(interlaced), .field_start(field_start),
    .field_id(field_id), .xfer_accept(xfer_accept), .wr_addr(wr_addr)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base1 = 32'h0; m_base2 = 32'h0; m_ptr = 32'h0;
    end else begin
      if (field_start) begin
        if (interlaced && !field_id) m_ptr = m_base1;
        else                         m_ptr = m_base2;
      end else if (xfer_accept) begin
        m_ptr = m_ptr + 32'd4;
      end
      if (base_we) begin
        if (base_sel) m_base2 = base_wdata & 32'hFFFF_FFF0;
        else          m_base1 = base_wdata & 32'hFFFF_FFF0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (wr_addr !== exp) begin
      failures++;
      $display("FAIL %s wr_addr actual=%h expected=%h", req, wr_addr, exp);
    end
  endtask

  // one clock, then compare with model and with an explicit expectation
  task automatic step(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req, m_ptr);
    base_we = 1'b0; field_start = 1'b0; xfer_accept = 1'b0;
  endtask

  task automatic wr_base(input logic sel, input logic [31:0] d, input string req);
    base_we = 1'b1; base_sel = sel; base_wdata = d;
    step(req);
  endtask

  task automatic start(input logic intl, input logic fid, input string req);
    interlaced = intl; field_id = fid; field_start = 1'b1;
    step(req);
  endtask

  task automatic accept(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      xfer_accept = 1'b1;
      step(req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'h0);

    // R2: low nibble dropped
    wr_base(1'b0, 32'h1000_0007, "R6");
    wr_base(1'b1, 32'h2000_002F, "R6");
    // R3: interlaced first field
    start(1'b1, 1'b0, "R3");
    check("R2 R3", 32'h1000_0000);
    accept(3, "R5");
    check("R5", 32'h1000_000C);
    step("R8");
    check("R8", 32'h1000_000C);
    // R6: mid-field base write does not disturb pointer
    wr_base(1'b1, 32'h3000_0040, "R6");
    check("R6", 32'h1000_000C);
    accept(1, "R5");
    check("R6", 32'h1000_0010);
    // R3: second field uses rewritten second base
    start(1'b1, 1'b1, "R3");
    check("R3 R6", 32'h3000_0040);
    // R4: progressive ignores field id
    accept(2, "R5");
    start(1'b0, 1'b0, "R4");
    check("R4", 32'h3000_0040);
    accept(1, "R5");
    start(1'b0, 1'b1, "R4");
    check("R4", 32'h3000_0040);
    // R7: reload beats accept
    accept(5, "R5");
    interlaced = 1'b1; field_id = 1'b0; field_start = 1'b1; xfer_accept = 1'b1;
    step("R7");
    check("R7", 32'h1000_0000);
    // R6: write in the same cycle as field start is not used by that reload
    base_we = 1'b1; base_sel = 1'b0; base_wdata = 32'h5555_5550;
    interlaced = 1'b1; field_id = 1'b0; field_start = 1'b1;
    step("R6");
    check("R6", 32'h1000_0000);
    start(1'b1, 1'b0, "R6");
    check("R6", 32'h5555_5550);
    // R9: wrap
    wr_base(1'b1, 32'hFFFF_FFF3, "R9");
    start(1'b0, 1'b0, "R9");
    check("R9", 32'hFFFF_FFF0);
    accept(4, "R9");
    check("R9", 32'h0000_0000);
    accept(1, "R9");
    check("R9", 32'h0000_0004);

    // random mix against the model: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 500; i++) begin
      base_we     = ($urandom % 8) == 0;
      base_sel    = 1'($urandom);
      base_wdata  = $urandom;
      interlaced  = 1'($urandom);
      field_id    = 1'($urandom);
      field_start = ($urandom % 16) == 0;
      xfer_accept = 1'($urandom);
      step("R3 R4 R5 R6 R7 R8");
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule